// File: doc/BRIEF.md
# Edge-Gated Supply Shunt Regulator Control

This block drives the control line of the shunt switch that holds the chip supply between two levels while the chip is in operating mode. Three comparator flags tell it where the supply stands. They show whether the supply is above the protection level, above the turn-on level, or below the turn-off level. The block takes these flags, the low-side logic input, the low-side gate output and an enable from the mode sequencer. When the switch is open, an external charge pump feeds the supply. When the switch is closed, the pump is shunted.

Normal decisions are taken only on a falling edge of the low-side logic input. This keeps switch changes aligned with the half-bridge. An over-protection condition closes the switch at once, without waiting for an edge. The two level thresholds act only after the first falling edge of the low-side gate output has been seen in the current enabled period. All inputs are asynchronous and pass through a synchronizer of `SYNC_STAGES` flops before any decision.

Top module: `tpr_regulator`

## Requirements
- R1: While enabled, an asserted over-protection flag closes the switch (`sw_on_o`=1) without any low-side input edge.
- R2: While enabled and armed, a falling edge of `ls_in_i` with the turn-on flag set closes the switch. Before that edge the switch does not change.
- R3: While enabled and armed, a falling edge of `ls_in_i` opens the switch when the turn-off flag is set and the turn-on and over-protection flags are clear. Before that edge the switch does not change.
- R4: While the enable is low, and out of reset, the switch is open whatever the other inputs do.
- R5: Before the first falling edge of `ls_gate_i` in an enabled period (not armed), the level flags and `ls_in_i` edges do not change the switch.
- R6: With no threshold condition at an edge, or with no edge at all and no over-protection, the switch keeps its state.
- R7: A falling enable clears the armed state. After re-enable, a new falling edge of `ls_gate_i` is needed before the level thresholds act again.
- R8: Over-protection wins over an edge-scheduled turn-off in the same cycle. The switch never opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_en_i | input | 1 | Operating-mode enable from the mode sequencer |
| vcc_over_prot_i | input | 1 | Supply above protection level |
| vcc_above_on_i | input | 1 | Supply above turn-on level |
| vcc_below_off_i | input | 1 | Supply below turn-off level |
| ls_in_i | input | 1 | Low-side logic input; its falling edge schedules decisions |
| ls_gate_i | input | 1 | Low-side gate output; its first falling edge arms the thresholds |
| sw_on_o | output | 1 | Shunt switch control, 1 = closed |

## Verification
The immediate over-protection path and an edge-scheduled turn-off can land in the same cycle. The bench provokes this with the switch closed and armed, the turn-off flag held, and `ls_in_i` high. It then raises the over-protection flag and drops `ls_in_i` on the same clock, so both reach the synchronizer output together. The switch is sampled on every cycle of the following window, and any single cycle with the switch open counts as a miscompare.

// File: rtl/tpr_pkg.sv
package tpr_pkg;
  typedef struct packed {
    logic en;
    logic over;
    logic above_on;
    logic below_off;
    logic ls_in;
    logic ls_gate;
  } tpr_in_t;
endpackage

// File: rtl/tpr_sync.sv
module tpr_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tpr_fall.sv
module tpr_fall #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= d_i;

  assign fall_o = prev_q & ~d_i;
endmodule

// File: rtl/tpr_ctrl.sv
module tpr_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic over_i,
  input  logic above_on_i,
  input  logic below_off_i,
  input  logic ls_fall_i,
  input  logic gate_fall_i,
  output logic armed_o,
  output logic sw_o
);
  logic armed_q, armed_d;
  logic sw_q, sw_d;

  always_comb begin
    armed_d = armed_q;
    if (!en_i)            armed_d = 1'b0;
    else if (gate_fall_i) armed_d = 1'b1;
  end

  // over-level path first, then edge-scheduled decisions, else hold
  always_comb begin
    sw_d = sw_q;
    if (!en_i)                       sw_d = 1'b0;
    else if (over_i)                 sw_d = 1'b1;
    else if (armed_q && ls_fall_i) begin
      if (above_on_i)                sw_d = 1'b1;
      else if (below_off_i)          sw_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      armed_q <= 1'b0;
      sw_q    <= 1'b0;
    end else begin
      armed_q <= armed_d;
      sw_q    <= sw_d;
    end

  assign armed_o = armed_q;
  assign sw_o    = sw_q;
endmodule

// File: rtl/tpr_regulator.sv
module tpr_regulator #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic op_en_i,
  input  logic vcc_over_prot_i,
  input  logic vcc_above_on_i,
  input  logic vcc_below_off_i,
  input  logic ls_in_i,
  input  logic ls_gate_i,
  output logic sw_on_o
);
  import tpr_pkg::*;

  localparam int NumIn = $bits(tpr_in_t);

  tpr_in_t    raw, syn;
  logic [1:0] fall;
  logic       en_s, over_s, on_s, off_s, ls_fall, gate_fall, armed;

  assign raw = '{en: op_en_i, over: vcc_over_prot_i, above_on: vcc_above_on_i,
                 below_off: vcc_below_off_i, ls_in: ls_in_i, ls_gate: ls_gate_i};

  tpr_sync #(.WIDTH(NumIn), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  tpr_fall #(.WIDTH(2)) u_fall (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({syn.ls_in, syn.ls_gate}),
    .fall_o(fall)
  );

  assign en_s      = syn.en;
  assign over_s    = syn.over;
  assign on_s      = syn.above_on;
  assign off_s     = syn.below_off;
  assign ls_fall   = fall[1];
  assign gate_fall = fall[0];

  tpr_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_s),
    .over_i     (over_s),
    .above_on_i (on_s),
    .below_off_i(off_s),
    .ls_fall_i  (ls_fall),
    .gate_fall_i(gate_fall),
    .armed_o    (armed),
    .sw_o       (sw_on_o)
  );
endmodule

// File: rtl/tpr_checker.sv
module tpr_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic en_s,
  input logic over_s,
  input logic on_s,
  input logic off_s,
  input logic ls_fall,
  input logic armed,
  input logic sw_on_o
);
  AST_OVER_FORCES_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_s && over_s |=> sw_on_o); // R1
  AST_EDGE_TURNS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_s && armed && ls_fall && on_s |=> sw_on_o); // R2
  AST_EDGE_TURNS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_s && armed && ls_fall && !over_s && !on_s && off_s |=> !sw_on_o); // R3
  AST_DISABLED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s |=> !sw_on_o); // R4
  AST_UNARMED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_s && !armed && !over_s |=> $stable(sw_on_o)); // R5
  AST_NO_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_s && !over_s && !ls_fall |=> $stable(sw_on_o)); // R6
  AST_ARM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s |=> !armed); // R7
  AST_OVER_BEATS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_s && over_s && armed && ls_fall && off_s |=> sw_on_o); // R8
endmodule

bind tpr_regulator tpr_checker u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_s   (en_s),
  .over_s (over_s),
  .on_s   (on_s),
  .off_s  (off_s),
  .ls_fall(ls_fall),
  .armed  (armed),
  .sw_on_o(sw_on_o)
);

// File: tb/tpr_regulator_bench.sv
`timescale 1ns/1ps
module tpr_regulator_bench;
  localparam time CLK_HALF = 10ns;
  localparam int  SETTLE   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, over = 1'b0, on_f = 1'b0, off_f = 1'b0, ls_in = 1'b0, ls_gate = 1'b0;
  logic sw;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #CLK_HALF clk = ~clk;

  tpr_regulator u_tpr_regulator (
    .clk_i(clk), .rst_ni(rst_n), .op_en_i(en), .vcc_over_prot_i(over),
    .vcc_above_on_i(on_f), .vcc_below_off_i(off_f), .ls_in_i(ls_in),
    .ls_gate_i(ls_gate), .sw_on_o(sw)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic exp);
    n_chk++;
    if (sw !== exp) begin
      n_bad++;
      $display("FAIL %s: sw_on_o=%b expected %b", tag, sw, exp);
    end
  endtask

  task automatic ls_pulse();
    ls_in = 1'b1; step(SETTLE);
    ls_in = 1'b0; step(SETTLE);
  endtask

  task automatic gate_pulse();
    ls_gate = 1'b1; step(SETTLE);
    ls_gate = 1'b0; step(SETTLE);
  endtask

  task automatic t_reset();
    step(2);
    check("R4 reset", 1'b0);
    rst_n = 1'b1; step(SETTLE);
    check("R4 after reset", 1'b0);
  endtask

  task automatic t_disabled();
    over = 1'b1; on_f = 1'b1;
    gate_pulse(); ls_pulse();
    check("R4 disabled with over", 1'b0);
    over = 1'b0; on_f = 1'b0;
  endtask

  task automatic t_over();
    en = 1'b1; step(SETTLE);
    check("R1 pre", 1'b0);
    over = 1'b1; step(SETTLE);
    check("R1 over closes without edge", 1'b1);
    over = 1'b0; step(SETTLE);
    check("R6 hold after over clears", 1'b1);
  endtask

  task automatic t_unarmed();
    off_f = 1'b1; ls_pulse();
    check("R5 unarmed ignores turn-off", 1'b1);
    off_f = 1'b0;
  endtask

  task automatic t_off_edge();
    gate_pulse();
    off_f = 1'b1; step(SETTLE);
    check("R3 waits for edge", 1'b1);
    ls_pulse();
    check("R3 opens at edge", 1'b0);
    off_f = 1'b0;
  endtask

  task automatic t_on_edge();
    ls_pulse();
    check("R6 no condition holds", 1'b0);
    on_f = 1'b1; step(SETTLE);
    check("R2 waits for edge", 1'b0);
    ls_pulse();
    check("R2 closes at edge", 1'b1);
    on_f = 1'b0;
  endtask

  task automatic t_priority();
    off_f = 1'b1; ls_in = 1'b1; step(SETTLE);
    over = 1'b1; ls_in = 1'b0;
    for (int i = 0; i < SETTLE; i++) begin
      step(1);
      check("R8 over beats edge turn-off", 1'b1);
    end
    over = 1'b0; step(SETTLE);
    ls_pulse();
    check("R3 turn-off after over clears", 1'b0);
    off_f = 1'b0;
  endtask

  task automatic t_rearm();
    on_f = 1'b1; ls_pulse();
    check("R2 closed before disable", 1'b1);
    on_f = 1'b0;
    en = 1'b0; step(SETTLE);
    check("R4 disable opens", 1'b0);
    en = 1'b1; on_f = 1'b1; step(SETTLE);
    ls_pulse();
    check("R7 arm cleared by disable", 1'b0);
    gate_pulse(); ls_pulse();
    check("R7 rearmed by gate edge", 1'b1);
    on_f = 1'b0;
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_over();
    t_unarmed();
    t_off_edge();
    t_on_edge();
    t_priority();
    t_rearm();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule